// File: doc/BRIEF.md
# VCO Sub-Band Search Sequencer

This block picks an oscillator and a sub-band so that a frequency synthesizer can lock. Three oscillators cover adjacent frequency ranges, and each is split into sixteen sub-bands. Together they form one ordered ladder of 48 bands. A trigger pulse starts a search. The search starts either at a band that software has programmed or at the band in use now.

For each candidate band the block waits a programmable settling time. It then reads a 3-bit code that describes the loop tuning voltage. A code at the bottom of the range means the band is too high, so the search moves one band down. A code at the top of the range means the band is too low, so the search moves one band up. Any code between the two means the band is usable, and the search stops with success. A step past the sixteenth sub-band carries into the next oscillator, in either direction. The search ends without success at either end of the ladder or after a bounded number of moves.

When the search function is switched off, the outputs follow the programmed band directly. The analog oscillators, the converter that produces the code and the loop itself are outside this block.

Top module: `vco_band_search`

## Requirements
- R1: During synchronous reset, and after it until other inputs take effect, `vco_sel`=00, `sub_sel`=0000, `idle`=1 and `found`=0.
- R2: While `search_en`=0, one clock edge later `vco_sel`/`sub_sel` equal `prog_vco`/`prog_sub`, with `idle`=1 and `found`=0. Any search in progress is dropped and `trig` has no effect.
- R3: A `trig` pulse with `search_en`=1 loads the start band at that edge, and the same edge sets `idle`=0 and `found`=0. The start band is the programmed band when `start_cur`=0 and the band on the outputs when `start_cur`=1.
- R4: The code is sampled `WAIT_BASE << wait_sel` clock edges after a band is applied. With `wait_sel` 00/01/10/11 that gives 1x/2x/4x/8x `WAIT_BASE`, which is 64/128/256/512 edges with the default parameters.
- R5: A sampled code from 001 to 110 ends the search: `idle`=1, `found`=1, and the band is held.
- R6: Code 000 moves one band down, and code 111 moves one band up. A move down from sub-band 0000 lands on sub-band 1111 of the next lower oscillator. A move up from 1111 lands on 0000 of the next higher oscillator. Oscillator codes 00, 01 and 10 run from the lowest range to the highest.
- R7: A move request below oscillator 00 sub-band 0000, or above oscillator 10 sub-band 1111, ends the search with `idle`=1, `found`=0 and the band held.
- R8: Once `STEP_LIMIT` moves have been made, a further move request ends the search with `found`=0 and the band held.
- R9: A `trig` that arrives during a search restarts it from the selected start band, with a fresh settling time and a cleared move count.
- R10: A start band with oscillator code 11 (shutdown) puts that band on the outputs and starts no search: `idle`=1, `found`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_en | input | 1 | 1 = automatic search, 0 = manual band |
| trig | input | 1 | Single-cycle start pulse |
| start_cur | input | 1 | 0 = start at programmed band, 1 = start at current band |
| prog_vco | input | VCO_W | Programmed oscillator code |
| prog_sub | input | SUB_W | Programmed sub-band |
| wait_sel | input | 2 | Settling time select |
| tune_code | input | CODE_W | Tuning-voltage window code |
| vco_sel | output | VCO_W | Oscillator in use |
| sub_sel | output | SUB_W | Sub-band in use |
| idle | output | 1 | 1 when no search is running |
| found | output | 1 | 1 after a successful search |

## Verification
The bench builds the block with `WAIT_BASE`=4 and `STEP_LIMIT`=12. At these values every settling time, from 4 to 32 edges, can be timed to the exact cycle. The move limit can be reached within a few hundred cycles by a code that keeps alternating direction. A band model that answers each sample from the band on the outputs drives searches across both oscillator boundaries, into both ends of the ladder, and through a restart partway through a search.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic [1:0] {
    CLS_LOW  = 2'd0,
    CLS_LOCK = 2'd1,
    CLS_HIGH = 2'd2
  } code_cls_t;
endpackage

// File: rtl/vbs_code_class.sv
module vbs_code_class
  import vbs_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output code_cls_t         cls
);
  always_comb begin
    if (code == '0)      cls = CLS_LOW;
    else if (&code)      cls = CLS_HIGH;
    else                 cls = CLS_LOCK;
  end
endmodule

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
  parameter int WAIT_BASE = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] wait_sel,
  output logic       expired
);
  localparam int MAX_WAIT = WAIT_BASE * 8;
  localparam int CNT_W    = $clog2(MAX_WAIT);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;

  always_comb begin
    span    = (CNT_W+1)'(WAIT_BASE) << wait_sel;
    expired = run && ({1'b0, cnt} == span - (CNT_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run)     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/vbs_band_step.sv
module vbs_band_step #(
  parameter int VCO_W     = 2,
  parameter int VCO_COUNT = 3,
  parameter int SUB_W     = 4
) (
  input  logic [VCO_W-1:0] vco,
  input  logic [SUB_W-1:0] sub,
  input  logic             up,
  output logic [VCO_W-1:0] nxt_vco,
  output logic [SUB_W-1:0] nxt_sub,
  output logic             at_end
);
  localparam logic [VCO_W-1:0] VCO_TOP = VCO_W'(VCO_COUNT - 1);

  always_comb begin
    nxt_vco = vco;
    nxt_sub = sub;
    if (up) begin
      at_end = (vco == VCO_TOP) && (&sub);
      if (&sub) begin
        nxt_sub = '0;
        nxt_vco = vco + VCO_W'(1);
      end else begin
        nxt_sub = sub + SUB_W'(1);
      end
    end else begin
      at_end = (vco == '0) && (sub == '0);
      if (sub == '0) begin
        nxt_sub = '1;
        nxt_vco = vco - VCO_W'(1);
      end else begin
        nxt_sub = sub - SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
  import vbs_pkg::*;
#(
  parameter int VCO_W      = 2,
  parameter int VCO_COUNT  = 3,
  parameter int SUB_W      = 4,
  parameter int CODE_W     = 3,
  parameter int WAIT_BASE  = 64,
  parameter int STEP_LIMIT = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              search_en,
  input  logic              trig,
  input  logic              start_cur,
  input  logic [VCO_W-1:0]  prog_vco,
  input  logic [SUB_W-1:0]  prog_sub,
  input  logic [1:0]        wait_sel,
  input  logic [CODE_W-1:0] tune_code,
  output logic [VCO_W-1:0]  vco_sel,
  output logic [SUB_W-1:0]  sub_sel,
  output logic              idle,
  output logic              found
);
  localparam int               STEP_W  = $clog2(STEP_LIMIT + 1);
  localparam logic [VCO_W-1:0] VCO_OFF = '1;

  logic [VCO_W-1:0]  vco_q;
  logic [SUB_W-1:0]  sub_q;
  logic              busy_q;
  logic              found_q;
  logic [STEP_W-1:0] steps_q;

  logic [VCO_W-1:0]  start_vco;
  logic [SUB_W-1:0]  start_sub;
  logic [VCO_W-1:0]  nxt_vco;
  logic [SUB_W-1:0]  nxt_sub;
  logic              at_end;
  logic              expired;
  logic              load;
  logic              move;
  logic              limit_hit;
  code_cls_t         cls;

  vbs_code_class #(.CODE_W(CODE_W)) u_class (
    .code (tune_code),
    .cls  (cls)
  );

  vbs_band_step #(
    .VCO_W     (VCO_W),
    .VCO_COUNT (VCO_COUNT),
    .SUB_W     (SUB_W)
  ) u_step (
    .vco     (vco_q),
    .sub     (sub_q),
    .up      (cls == CLS_HIGH),
    .nxt_vco (nxt_vco),
    .nxt_sub (nxt_sub),
    .at_end  (at_end)
  );

  vbs_settle_timer #(.WAIT_BASE(WAIT_BASE)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (load || move),
    .run      (busy_q && search_en),
    .wait_sel (wait_sel),
    .expired  (expired)
  );

  always_comb begin
    start_vco = start_cur ? vco_q : prog_vco;
    start_sub = start_cur ? sub_q : prog_sub;
    load      = search_en && trig;
    limit_hit = (steps_q == STEP_W'(STEP_LIMIT));
    move      = search_en && !trig && busy_q && expired &&
                (cls != CLS_LOCK) && !at_end && !limit_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vco_q   <= '0;
      sub_q   <= '0;
      busy_q  <= 1'b0;
      found_q <= 1'b0;
      steps_q <= '0;
    end else if (!search_en) begin
      vco_q   <= prog_vco;
      sub_q   <= prog_sub;
      busy_q  <= 1'b0;
      found_q <= 1'b0;
    end else if (load) begin
      vco_q   <= start_vco;
      sub_q   <= start_sub;
      found_q <= 1'b0;
      busy_q  <= (start_vco != VCO_OFF);
      steps_q <= '0;
    end else if (busy_q && expired) begin
      if (cls == CLS_LOCK) begin
        busy_q  <= 1'b0;
        found_q <= 1'b1;
      end else if (move) begin
        vco_q   <= nxt_vco;
        sub_q   <= nxt_sub;
        steps_q <= steps_q + STEP_W'(1);
      end else begin
        busy_q  <= 1'b0;
      end
    end
  end

  assign vco_sel = vco_q;
  assign sub_sel = sub_q;
  assign idle    = !busy_q;
  assign found   = found_q;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
  parameter int VCO_W  = 2,
  parameter int SUB_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             search_en,
  input logic             trig,
  input logic             start_cur,
  input logic [VCO_W-1:0] prog_vco,
  input logic [SUB_W-1:0] prog_sub,
  input logic [VCO_W-1:0] vco_sel,
  input logic [SUB_W-1:0] sub_sel,
  input logic             idle,
  input logic             found
);
  localparam int BW = VCO_W + SUB_W;
  logic [BW-1:0]    band;
  logic [VCO_W-1:0] start_vco;
  assign band      = {vco_sel, sub_sel};
  assign start_vco = start_cur ? vco_sel : prog_vco;

  a_r2_manual_follow: assert property (@(posedge clk) disable iff (rst)
    !search_en |=> (vco_sel == $past(prog_vco)) && (sub_sel == $past(prog_sub)) && idle && !found);

  a_r3_trig_starts: assert property (@(posedge clk) disable iff (rst)
    (search_en && trig && (start_vco != '1)) |=> (!idle && !found));

  a_r5_found_only_idle: assert property (@(posedge clk) disable iff (rst)
    found |-> idle);

  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    (search_en && !idle && !trig) |=>
      ((band == $past(band)) || (band == $past(band) + BW'(1)) || (band == $past(band) - BW'(1))));

  a_r10_no_search_off: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (vco_sel != '1));
endmodule

bind vco_band_search vbs_checker #(.VCO_W(VCO_W), .SUB_W(SUB_W)) u_vbs_checker (
  .clk       (clk),
  .rst       (rst),
  .search_en (search_en),
  .trig      (trig),
  .start_cur (start_cur),
  .prog_vco  (prog_vco),
  .prog_sub  (prog_sub),
  .vco_sel   (vco_sel),
  .sub_sel   (sub_sel),
  .idle      (idle),
  .found     (found)
);

// File: tb/vco_band_search_bench.sv
module vco_band_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WB         = 4;
  localparam int LIM        = 12;
  localparam int SUBS       = 16;
  localparam int LADDER     = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       search_en = 1'b0;
  logic       trig = 1'b0;
  logic       start_cur = 1'b0;
  logic [1:0] prog_vco = 2'b01;
  logic [3:0] prog_sub = 4'b0101;
  logic [1:0] wait_sel = 2'b00;
  logic [2:0] tune_code = 3'b011;
  logic [1:0] vco_sel;
  logic [3:0] sub_sel;
  logic       idle;
  logic       found;

  always #(CLK_PERIOD/2) clk = ~clk;

  vco_band_search #(.WAIT_BASE(WB), .STEP_LIMIT(LIM)) u_vco_band_search (
    .clk(clk), .rst(rst), .search_en(search_en), .trig(trig), .start_cur(start_cur),
    .prog_vco(prog_vco), .prog_sub(prog_sub), .wait_sel(wait_sel), .tune_code(tune_code),
    .vco_sel(vco_sel), .sub_sel(sub_sel), .idle(idle), .found(found)
  );

  // behavioural reference: the band is one index on a 48-rung ladder
  int m_idx = 0, m_busy = 0, m_found = 0, m_rem = 0, m_moves = 0;
  always @(posedge clk) begin
    int code, s;
    code = int'(tune_code);
    if (rst) begin
      m_idx = 0; m_busy = 0; m_found = 0;
    end else if (!search_en) begin
      m_idx = int'(prog_vco) * SUBS + int'(prog_sub); m_busy = 0; m_found = 0;
    end else if (trig) begin
      s = start_cur ? m_idx : int'(prog_vco) * SUBS + int'(prog_sub);
      m_idx = s; m_found = 0; m_busy = (s < LADDER) ? 1 : 0;
      m_moves = 0; m_rem = WB << wait_sel;
    end else if (m_busy == 1) begin
      m_rem = m_rem - 1;
      if (m_rem == 0) begin
        if (code >= 1 && code <= 6) begin
          m_busy = 0; m_found = 1;
        end else if (m_moves == LIM) begin
          m_busy = 0;
        end else if (code == 0 && m_idx == 0) begin
          m_busy = 0;
        end else if (code == 7 && m_idx == LADDER - 1) begin
          m_busy = 0;
        end else begin
          m_idx = (code == 0) ? m_idx - 1 : m_idx + 1;
          m_moves++; m_rem = WB << wait_sel;
        end
      end
    end
  end

  int checks = 0, failures = 0, cyc = 0;
  int mode = 0, tgt = 0;
  logic [2:0] lock_code = 3'b011;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    int b;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    chk(int'(vco_sel) == m_idx / SUBS, cur_req, "vco_sel", int'(vco_sel), m_idx / SUBS);
    chk(int'(sub_sel) == m_idx % SUBS, cur_req, "sub_sel", int'(sub_sel), m_idx % SUBS);
    chk(int'(idle) == 1 - m_busy, cur_req, "idle", int'(idle), 1 - m_busy);
    chk(int'(found) == m_found, cur_req, "found", int'(found), m_found);
    b = int'({vco_sel, sub_sel});
    case (mode)
      0: tune_code = (b > tgt) ? 3'b000 : (b < tgt) ? 3'b111 : lock_code;
      1: tune_code = b[0] ? 3'b000 : 3'b111;
      2: tune_code = 3'b000;
      default: tune_code = 3'b111;
    endcase
  endtask

  task automatic pulse();
    trig = 1'b1; step(); trig = 1'b0;
  endtask

  task automatic run_idle(output int n);
    n = 0;
    while (!idle && n < 5000) begin step(); n++; end
  endtask

  int n;
  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) step();
    chk(vco_sel == 2'b00 && sub_sel == 4'b0000, "R1", "reset band", int'({vco_sel, sub_sel}), 0);
    chk(idle == 1'b1 && found == 1'b0, "R1", "reset flags", int'({idle, found}), 2);
    rst = 1'b0;

    // R2 manual mode follows programmed band, trig ignored
    cur_req = "R2";
    prog_vco = 2'b10; prog_sub = 4'b0011;
    pulse(); step();
    chk({vco_sel, sub_sel} == 6'b10_0011 && idle, "R2", "manual band", int'({vco_sel, sub_sel}), 35);

    // R3/R6/R5/R4: up search, start at programmed band 01/0101 to 01/1000
    cur_req = "R6";
    search_en = 1'b1; start_cur = 1'b0; prog_vco = 2'b01; prog_sub = 4'b0101;
    mode = 0; tgt = 24; lock_code = 3'b001; wait_sel = 2'b00;
    step();
    pulse();
    chk(idle == 1'b0 && found == 1'b0, "R3", "busy after trig", int'(idle), 0);
    chk({vco_sel, sub_sel} == 6'b01_0101, "R3", "start band", int'({vco_sel, sub_sel}), 21);
    run_idle(n);
    chk(n == 4 * WB, "R4", "settle edges wait_sel=0", n, 4 * WB);
    chk(found && {vco_sel, sub_sel} == 6'b01_1000, "R5", "lock band", int'({vco_sel, sub_sel}), 24);

    // R6 down across oscillator boundary, wait_sel=2
    prog_sub = 4'b0001; tgt = 14; wait_sel = 2'b10; lock_code = 3'b110;
    pulse(); run_idle(n);
    chk(n == 4 * (WB << 2), "R4", "settle edges wait_sel=2", n, 4 * (WB << 2));
    chk(found && {vco_sel, sub_sel} == 6'b00_1110, "R6", "down carry", int'({vco_sel, sub_sel}), 14);

    // R3 start at current band, R6 up across boundary
    cur_req = "R3";
    start_cur = 1'b1; prog_vco = 2'b10; prog_sub = 4'b0000; tgt = 18; wait_sel = 2'b00;
    pulse();
    chk({vco_sel, sub_sel} == 6'b00_1110, "R3", "start at current", int'({vco_sel, sub_sel}), 14);
    run_idle(n);
    chk(found && {vco_sel, sub_sel} == 6'b01_0010, "R6", "up carry", int'({vco_sel, sub_sel}), 18);

    // R7 floor and ceiling
    cur_req = "R7";
    start_cur = 1'b0; mode = 2; prog_vco = 2'b00; prog_sub = 4'b0010;
    pulse(); run_idle(n);
    chk(!found && {vco_sel, sub_sel} == 6'b00_0000, "R7", "floor fail", int'({vco_sel, sub_sel}), 0);
    mode = 3; prog_vco = 2'b10; prog_sub = 4'b1101;
    pulse(); run_idle(n);
    chk(!found && {vco_sel, sub_sel} == 6'b10_1111, "R7", "ceiling fail", int'({vco_sel, sub_sel}), 47);

    // R8 move limit by alternating code
    cur_req = "R8";
    mode = 1; prog_vco = 2'b01; prog_sub = 4'b0000; wait_sel = 2'b01;
    pulse(); run_idle(n);
    chk(n == (LIM + 1) * (WB << 1), "R8", "edges to limit", n, (LIM + 1) * (WB << 1));
    chk(!found && idle, "R8", "limit fail flags", int'({idle, found}), 2);

    // R9 restart during search
    cur_req = "R9";
    mode = 0; tgt = 40; lock_code = 3'b011; prog_vco = 2'b01; prog_sub = 4'b0000;
    pulse();
    repeat (20) step();
    chk(idle == 1'b0, "R9", "still busy", int'(idle), 0);
    prog_vco = 2'b10; prog_sub = 4'b0110;
    pulse();
    chk({vco_sel, sub_sel} == 6'b10_0110, "R9", "restart band", int'({vco_sel, sub_sel}), 38);
    run_idle(n);
    chk(n == 3 * (WB << 1) && found, "R9", "restart edges", n, 3 * (WB << 1));

    // R10 shutdown code as start
    cur_req = "R10";
    prog_vco = 2'b11; prog_sub = 4'b0011;
    pulse();
    chk(idle && !found && {vco_sel, sub_sel} == 6'b11_0011, "R10", "off start", int'({vco_sel, sub_sel}), 51);

    // R2 disable mid-search
    cur_req = "R2";
    prog_vco = 2'b00; prog_sub = 4'b0101; tgt = 30;
    pulse(); step(); step();
    search_en = 1'b0; prog_vco = 2'b01; prog_sub = 4'b1100;
    step();
    chk(idle && !found && {vco_sel, sub_sel} == 6'b01_1100, "R2", "abort to manual", int'({vco_sel, sub_sel}), 28);
    repeat (3) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule